// File: doc/BRIEF.md
# Hart Trap Entry Sequencer

This block performs trap entry for a hart with three privilege levels: user, supervisor and machine. When the core presents a one-cycle trap event, the block selects the handling level. The event carries an interrupt flag, a cause number, the faulting address and the pc of the trapped instruction. The block then records the trap in that level's cause, exception-pc and trap-value registers, and updates that level's interrupt-enable stack. On the next cycle it raises a one-cycle redirect carrying the handler address, and it switches privilege.

The privilege register is the block's state machine. It has three named states: `PRIV_U` (encoding 00), `PRIV_S` (01) and `PRIV_M` (11).
- Transition *trap-to-supervisor* leads from `PRIV_U` or `PRIV_S` to `PRIV_S`.
- Transition *trap-to-machine* leads from any state to `PRIV_M`.
- Transition *context-load* moves to the level written on the load port. The surrounding core's return and control-register logic uses this port to hand back a privilege level and the two live interrupt enables.
- With no trap and no load, the state holds (*idle*).

Delegation masks and both vector bases come in as inputs.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is machine (11), every enable, previous-enable and previous-privilege field is 0, all six trap registers are 0, and `redirect_o` is low.
- R2: A trap is handled in supervisor mode only if all three of these hold:
  - the current privilege is user or supervisor;
  - the effective cause is below XLEN;
  - the cause's bit is set in the delegation mask, taken from `int_deleg_i` for interrupts and from `exc_deleg_i` for exceptions.
  Every other trap is handled in machine mode.
- R3: On supervisor handling, the supervisor previous-enable bit takes the old supervisor enable. The supervisor previous-privilege bit becomes 1 if the hart was in supervisor mode and 0 if it was in user mode. The supervisor enable clears, and the privilege becomes supervisor.
- R4: On machine handling, the machine previous-enable bit takes the old machine enable. The machine previous-privilege field takes the old 2-bit privilege, the machine enable clears, and the privilege becomes machine.
- R5: The handling level's cause register gets the effective cause in its low bits and zero above it. Bit XLEN-1 is set for interrupts.
- R6: The handling level's exception-pc register gets `trap_pc_i`.
- R7: The handling level's trap-value register gets `trap_addr_i` for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It gets 0 for every other exception cause and for every interrupt.
- R8: The handler pc is the handling level's vector base with bits 1:0 cleared. Four times the cause is added only when the base's bits 1:0 equal 01 and the trap is an interrupt.
- R9: Exception cause 8 is rewritten before routing as 8, 9 or 11 when the current privilege is user, supervisor or machine.
- R10: A trap pulse in cycle N gives `redirect_o` high in cycle N+1 only, with all registers updated in the same cycle. Back-to-back pulses give back-to-back redirects. The level that does not handle the trap keeps its registers.
- R11: A context load, with no trap in the same cycle, sets the privilege and both live enables in the next cycle. Privilege code 10 loads as user.
- R12: When a trap and a context load fall in the same cycle, the trap wins and the load is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | One-cycle trap event |
| trap_irq_i | input | 1 | Event is an interrupt |
| trap_cause_i | input | CAUSE_W | Raw cause number |
| trap_addr_i | input | XLEN | Faulting address |
| trap_pc_i | input | XLEN | Pc of the trapped instruction |
| int_deleg_i | input | XLEN | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor vector base and mode |
| mtvec_i | input | XLEN | Machine vector base and mode |
| ctx_load_i | input | 1 | Context load strobe |
| ctx_priv_i | input | 2 | Privilege to load |
| ctx_sie_i | input | 1 | Supervisor enable to load |
| ctx_mie_i | input | 1 | Machine enable to load |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception pc |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception pc |
| mtval_o | output | XLEN | Machine trap value |
| redirect_o | output | 1 | Handler redirect pulse |
| redirect_pc_o | output | XLEN | Handler address |

## Verification
A trap and a context load can arrive in the same cycle. The bench drives both strobes together from machine mode, with a load that asks for user privilege and set enables. It then checks that the privilege, both enables and the machine stack match a pure trap entry. Back-to-back trap pulses are also run, and each redirect is matched in order against the scoreboard's expected handler pc and register set.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    localparam int ECALL_BASE = 8;

    function automatic priv_e decode_priv(input logic [1:0] code);
        case (code)
            2'b01:   return PRIV_S;
            2'b11:   return PRIV_M;
            default: return PRIV_U;
        endcase
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  priv_e               priv,
    input  logic                irq,
    input  logic [CAUSE_W-1:0]  cause,
    input  logic [XLEN-1:0]     addr,
    input  logic [XLEN-1:0]     int_deleg,
    input  logic [XLEN-1:0]     exc_deleg,
    output logic                to_sup,
    output logic [CAUSE_W-1:0]  eff_cause,
    output logic [XLEN-1:0]     tval
);
    localparam int IDX_W  = $clog2(XLEN);
    localparam int WIDE_W = CAUSE_W + IDX_W;

    logic [WIDE_W-1:0] wide_cause;
    logic [XLEN-1:0]   mask;
    logic              in_range;
    logic              addr_cause;

    // environment-call cause depends on the level that issued it
    always_comb begin
        eff_cause = cause;
        if (!irq && cause == CAUSE_W'(ECALL_BASE)) begin
            unique case (priv)
                PRIV_U: eff_cause = CAUSE_W'(ECALL_BASE);
                PRIV_S: eff_cause = CAUSE_W'(ECALL_BASE + 1);
                PRIV_M: eff_cause = CAUSE_W'(ECALL_BASE + 3);
                default: eff_cause = cause;
            endcase
        end
    end

    assign wide_cause = WIDE_W'(eff_cause);
    assign in_range   = wide_cause < WIDE_W'(XLEN);
    assign mask       = irq ? int_deleg : exc_deleg;
    assign to_sup     = (priv != PRIV_M) && in_range && mask[wide_cause[IDX_W-1:0]];

    always_comb begin
        case (wide_cause)
            WIDE_W'(0), WIDE_W'(1), WIDE_W'(4), WIDE_W'(5),
            WIDE_W'(6), WIDE_W'(7), WIDE_W'(12), WIDE_W'(13),
            WIDE_W'(15): addr_cause = 1'b1;
            default:     addr_cause = 1'b0;
        endcase
    end

    assign tval = (!irq && addr_cause) ? addr : '0;

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    handler_pc
);
    localparam logic [1:0] MODE_VECTORED = 2'b01;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base       = {tvec[XLEN-1:2], 2'b00};
    assign offset     = (irq && tvec[1:0] == MODE_VECTORED) ? (XLEN'(cause) << 2) : '0;
    assign handler_pc = base + offset;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid_i,
    input  logic               trap_irq_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    trap_addr_i,
    input  logic [XLEN-1:0]    trap_pc_i,
    input  logic [XLEN-1:0]    int_deleg_i,
    input  logic [XLEN-1:0]    exc_deleg_i,
    input  logic [XLEN-1:0]    stvec_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic               ctx_load_i,
    input  logic [1:0]         ctx_priv_i,
    input  logic               ctx_sie_i,
    input  logic               ctx_mie_i,
    output logic [1:0]         priv_o,
    output logic               sie_o,
    output logic               spie_o,
    output logic               spp_o,
    output logic               mie_o,
    output logic               mpie_o,
    output logic [1:0]         mpp_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    priv_e              priv_q, priv_d;
    logic               to_sup;
    logic [CAUSE_W-1:0] eff_cause;
    logic [XLEN-1:0]    tval_sel, tvec_sel, handler_pc, cause_word;

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .priv      (priv_q),
        .irq       (trap_irq_i),
        .cause     (trap_cause_i),
        .addr      (trap_addr_i),
        .int_deleg (int_deleg_i),
        .exc_deleg (exc_deleg_i),
        .to_sup    (to_sup),
        .eff_cause (eff_cause),
        .tval      (tval_sel)
    );

    assign tvec_sel = to_sup ? stvec_i : mtvec_i;

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .tvec       (tvec_sel),
        .irq        (trap_irq_i),
        .cause      (eff_cause),
        .handler_pc (handler_pc)
    );

    assign cause_word = {trap_irq_i, {PAD_W{1'b0}}, eff_cause};

    // privilege state register
    always_ff @(posedge clk) begin
        if (!rst_n) priv_q <= PRIV_M;
        else        priv_q <= priv_d;
    end

    // transitions: trap-to-supervisor, trap-to-machine, context-load, idle
    always_comb begin
        priv_d = priv_q;
        unique case (priv_q)
            PRIV_U, PRIV_S: begin
                if (trap_valid_i)    priv_d = to_sup ? PRIV_S : PRIV_M;
                else if (ctx_load_i) priv_d = decode_priv(ctx_priv_i);
            end
            PRIV_M: begin
                if (trap_valid_i)    priv_d = PRIV_M;
                else if (ctx_load_i) priv_d = decode_priv(ctx_priv_i);
            end
            default: priv_d = PRIV_M;
        endcase
    end

    // per-level trap registers and redirect outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sie_o <= 1'b0; spie_o <= 1'b0; spp_o <= 1'b0;
            mie_o <= 1'b0; mpie_o <= 1'b0; mpp_o <= 2'b00;
            scause_o <= '0; sepc_o <= '0; stval_o <= '0;
            mcause_o <= '0; mepc_o <= '0; mtval_o <= '0;
            redirect_o <= 1'b0; redirect_pc_o <= '0;
        end else begin
            redirect_o <= trap_valid_i;
            if (trap_valid_i) begin
                redirect_pc_o <= handler_pc;
                if (to_sup) begin
                    spie_o   <= sie_o;
                    spp_o    <= (priv_q == PRIV_S);
                    sie_o    <= 1'b0;
                    scause_o <= cause_word;
                    sepc_o   <= trap_pc_i;
                    stval_o  <= tval_sel;
                end else begin
                    mpie_o   <= mie_o;
                    mpp_o    <= priv_q;
                    mie_o    <= 1'b0;
                    mcause_o <= cause_word;
                    mepc_o   <= trap_pc_i;
                    mtval_o  <= tval_sel;
                end
            end else if (ctx_load_i) begin
                sie_o <= ctx_sie_i;
                mie_o <= ctx_mie_i;
            end
        end
    end

    assign priv_o = priv_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trap_valid_i,
    input logic       ctx_load_i,
    input logic [1:0] ctx_priv_i,
    input logic [1:0] priv_o,
    input logic       sie_o,
    input logic       mie_o,
    input logic       redirect_o
);
    // R10
    redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> redirect_o);

    // R10
    redirect_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> $past(trap_valid_i));

    // R2
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && priv_o == 2'b11) |=> priv_o == 2'b11);

    // R3 R4
    enable_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> ((priv_o == 2'b11 && !mie_o) || (priv_o == 2'b01 && !sie_o)));

    // R11
    reserved_to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load_i && !trap_valid_i && ctx_priv_i == 2'b10) |=> priv_o == 2'b00);

    // R1
    legal_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_o != 2'b10);
endmodule

bind trap_entry_unit trap_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_valid_i (trap_valid_i),
    .ctx_load_i   (ctx_load_i),
    .ctx_priv_i   (ctx_priv_i),
    .priv_o       (priv_o),
    .sie_o        (sie_o),
    .mie_o        (mie_o),
    .redirect_o   (redirect_o)
);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
    localparam int XLEN = 32;
    localparam int CW   = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic trap_valid_i = 0, trap_irq_i = 0, ctx_load_i = 0, ctx_sie_i = 0, ctx_mie_i = 0;
    logic [CW-1:0] trap_cause_i = '0;
    logic [XLEN-1:0] trap_addr_i = '0, trap_pc_i = '0;
    logic [XLEN-1:0] int_deleg_i = 32'h0000_0022;
    logic [XLEN-1:0] exc_deleg_i = 32'h0000_2104;
    logic [XLEN-1:0] stvec_i = 32'h8000_1001;
    logic [XLEN-1:0] mtvec_i = 32'h0000_2002;
    logic [1:0] ctx_priv_i = 2'b00;
    logic [1:0] priv_o, mpp_o;
    logic sie_o, spie_o, spp_o, mie_o, mpie_o, redirect_o;
    logic [XLEN-1:0] scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o, redirect_pc_o;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CW)) uut (.*);

    typedef struct {
        logic [1:0] priv; logic sie, spie, spp, mie, mpie; logic [1:0] mpp;
        logic [31:0] scause, sepc, stval, mcause, mepc, mtval, pc;
    } exp_t;

    exp_t m;
    exp_t sb[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit addr_cause(int c);
        case (c)
            0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // driver: computes the expected outcome from the requirements and queues it
    task automatic fire(bit irq, int cause, logic [31:0] addr, logic [31:0] pc,
                        bit with_ctx = 0, logic [1:0] cpriv = 2'b00);
        int eff; bit to_s; logic [31:0] tv, vec, cw;
        eff = cause;
        if (!irq && cause == 8) eff = (m.priv == 2'b00) ? 8 : (m.priv == 2'b01) ? 9 : 11; // R9
        to_s = (m.priv != 2'b11) && (eff < 32) && (irq ? int_deleg_i[eff % 32] : exc_deleg_i[eff % 32]); // R2
        tv  = (!irq && addr_cause(eff)) ? addr : 32'h0;             // R7
        vec = to_s ? stvec_i : mtvec_i;
        cw  = {irq, 31'(eff)};                                       // R5
        m.pc = {vec[31:2], 2'b00} + ((irq && vec[1:0] == 2'b01) ? 32'(eff * 4) : 32'h0); // R8
        if (to_s) begin
            m.spie = m.sie; m.spp = (m.priv == 2'b01); m.sie = 0;
            m.scause = cw; m.sepc = pc; m.stval = tv; m.priv = 2'b01;
        end else begin
            m.mpie = m.mie; m.mpp = m.priv; m.mie = 0;
            m.mcause = cw; m.mepc = pc; m.mtval = tv; m.priv = 2'b11;
        end
        sb.push_back(m);
        @(negedge clk);
        trap_valid_i = 1; trap_irq_i = irq; trap_cause_i = CW'(cause);
        trap_addr_i = addr; trap_pc_i = pc;
        ctx_load_i = with_ctx; ctx_priv_i = cpriv; ctx_sie_i = with_ctx; ctx_mie_i = with_ctx;
    endtask

    task automatic idle();
        @(negedge clk);
        trap_valid_i = 0; ctx_load_i = 0;
    endtask

    task automatic load_ctx(logic [1:0] p, bit s, bit mi);
        @(negedge clk);
        trap_valid_i = 0; ctx_load_i = 1; ctx_priv_i = p; ctx_sie_i = s; ctx_mie_i = mi;
        m.priv = (p == 2'b01) ? 2'b01 : (p == 2'b11) ? 2'b11 : 2'b00;
        m.sie = s; m.mie = mi;
        @(negedge clk);
        ctx_load_i = 0;
        chk("R11 priv", priv_o, m.priv);
        chk("R11 sie", sie_o, m.sie);
        chk("R11 mie", mie_o, m.mie);
    endtask

    // monitor: each redirect is matched against the oldest expected entry
    always @(negedge clk) begin
        if (rst_n && redirect_o) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: actual redirect 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R2 priv", priv_o, e.priv);
                chk("R3 sie", sie_o, e.sie);
                chk("R3 spie", spie_o, e.spie);
                chk("R3 spp", spp_o, e.spp);
                chk("R4 mie", mie_o, e.mie);
                chk("R4 mpie", mpie_o, e.mpie);
                chk("R4 mpp", mpp_o, e.mpp);
                chk("R5 scause", scause_o, e.scause);
                chk("R5 mcause", mcause_o, e.mcause);
                chk("R6 sepc", sepc_o, e.sepc);
                chk("R6 mepc", mepc_o, e.mepc);
                chk("R7 stval", stval_o, e.stval);
                chk("R7 mtval", mtval_o, e.mtval);
                chk("R8 pc", redirect_pc_o, e.pc);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m = '{priv: 2'b11, sie: 0, spie: 0, spp: 0, mie: 0, mpie: 0, mpp: 2'b00,
              scause: 0, sepc: 0, stval: 0, mcause: 0, mepc: 0, mtval: 0, pc: 0};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        chk("R1 priv", priv_o, 2'b11);
        chk("R1 status", {sie_o, spie_o, spp_o, mie_o, mpie_o, mpp_o}, 0);
        chk("R1 trap regs", scause_o | sepc_o | stval_o | mcause_o | mepc_o | mtval_o, 0);
        chk("R1 redirect", redirect_o, 0);

        fire(0, 13, 32'hDEAD_0040, 32'h0000_1000); idle();   // R2 delegated but from machine
        load_ctx(2'b00, 1, 1);
        fire(0, 8, 32'h1111_1111, 32'h0000_1100); idle();    // R9 user ecall to supervisor
        fire(1, 5, 32'h0, 32'h8000_1200); idle();            // R8 vectored supervisor interrupt
        fire(0, 8, 32'h0, 32'h8000_1300); idle();            // R9 supervisor ecall to machine
        load_ctx(2'b10, 1, 1);                                // R11 code 10 loads user
        fire(1, 7, 32'h0, 32'h0000_1400); idle();            // R8 machine mode 2 not vectored
        load_ctx(2'b01, 1, 1);
        fire(0, 40, 32'h5555_0000, 32'h8000_1500); idle();   // R2 cause above XLEN
        load_ctx(2'b00, 0, 1);
        fire(0, 2, 32'hABCD_0000, 32'h0000_1600); idle();    // R7 non-address cause
        fire(0, 13, 32'hCAFE_0008, 32'h8000_1700); idle();   // R7 page fault from supervisor
        load_ctx(2'b11, 0, 1);
        fire(0, 8, 32'h0, 32'h0000_1800); idle();            // R9 machine ecall
        fire(0, 1, 32'h0BAD_0004, 32'h0000_1900, 1, 2'b00); idle(); // R12 trap beats load
        chk("R12 priv", priv_o, 2'b11);
        chk("R12 mie", mie_o, 0);
        load_ctx(2'b00, 1, 1);
        fire(1, 1, 32'h0, 32'h0000_1A00);                    // R10 back-to-back
        fire(0, 4, 32'h0000_0F03, 32'h8000_1B00); idle();
        repeat (3) @(negedge clk);
        chk("R10 queue drained", sb.size(), 0);
        finish_run();
    end
endmodule